// File: doc/BRIEF.md
# Host Message Frame Buffer

This block holds one message frame of up to 19 bytes and shares it between the host-side register window and the message engine. A frame starts with a byte count that includes itself, then a service selector, then up to 17 parameter bytes. When the host writes through the window, the buffer collects the bytes and checks them against the leading count. When the frame is complete it raises a pending request, which the message engine reads back through its own address port.

The engine sends frames the other way, confirmations and incoming indications. It writes the bytes into the same storage and posts them. A posted frame raises the interrupt request, and the host reads it byte by byte through the window. The frame is released when the host reads its last counted byte, or when the host ends a read transfer early. Only one frame can be in flight. If the engine posts while the buffer is taken, the post is refused and an overrun error code is raised.

Each transfer starts at window offset 0. Every host write or read acknowledge moves the offset forward by one. The transfer-end strobe returns the offset to 0.

Top module: `hfb_frame_buffer`

## Requirements
- R1: After reset, `irq`, `req_pending` and `overrun` are 0, `err_code` is 00h, and `host_rd_data` shows 00h at offset 0.
- R2: A host write transfer whose first byte N is at least 3 sets `req_pending` in the cycle after the byte at offset N-1 is written. Before that byte, `req_pending` stays 0. The stored bytes can then be read on `eng_rd_data` at their offsets.
- R3: Host bytes written after the counted byte in the same transfer do not change the buffer.
- R4: If the count is larger than 19, the frame is submitted when offset 18 is written.
- R5: A first byte below 3 (00h, 01h or 02h) marks the frame invalid. Nothing is submitted for the rest of that transfer.
- R6: If a write transfer ends before the counted bytes have arrived, the partial frame is dropped without any submission. The next transfer starts a new frame.
- R7: While a request is pending, host writes are ignored and the buffer keeps the request bytes.
- R8: A post made while the state is idle or request-pending clears `req_pending` at the next edge. `irq` rises one cycle after the frame becomes pending.
- R9: While a frame is pending, a read at an offset below the count returns the stored byte. Reads at or beyond the count return FFh.
- R10: When no frame is pending, a read returns 00h at offset 0 and FFh at every later offset.
- R11: Reading the last counted byte releases the frame, and `irq` falls one cycle later. A following read transfer sees 00h at offset 0.
- R12: If a read transfer ends after at least one byte but before the last counted byte, the frame is discarded and `irq` falls one cycle later.
- R13: A post made while a frame is pending for the host, or while the host is filling a frame, is refused. `overrun` pulses for one cycle, `err_code` becomes 03h, and engine writes made in that state leave the pending frame unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host writes one byte at the current window offset |
| host_wr_data | input | 8 | Host write byte |
| host_rd_ack | input | 1 | Host has taken the byte on `host_rd_data`; the offset advances |
| host_xfer_end | input | 1 | Host transfer ended (stop); the offset returns to 0 |
| host_rd_data | output | 8 | Byte presented at the current window offset |
| eng_wr_en | input | 1 | Engine writes one byte at `eng_addr` |
| eng_addr | input | 5 | Engine byte address for reads and writes |
| eng_wr_data | input | 8 | Engine write byte |
| eng_post | input | 1 | Engine publishes the buffered frame to the host |
| eng_rd_data | output | 8 | Buffer byte at `eng_addr` |
| req_pending | output | 1 | A complete host request waits for the engine |
| irq | output | 1 | Interrupt request: a frame waits for the host |
| overrun | output | 1 | One-cycle pulse when a post is refused |
| err_code | output | 8 | Last error code (03h = overrun) |

## Verification
The bench goes after the points where the leading count and the end of the transfer decide the outcome. It checks submission on exactly the counted byte, the cap at offset 18, counts below 3 and a stop that comes too early. A design that got these wrong would submit one byte early or late, hang on an oversized count, or send a truncated request. On the read side it checks FFh padding past the count, release on the last counted byte, and discard on an abandoned read. It also checks the one-cycle lag of the interrupt, which a wrong design would show as a stuck interrupt or as a frame that can be read twice. A refused post is checked to leave the pending frame intact, catching a design that overwrites it.

// File: rtl/hfb_pkg.sv
package hfb_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] CODE_OVERRUN = 8'h03;
    localparam logic [BYTE_W-1:0] BYTE_EMPTY   = 8'h00;
    localparam logic [BYTE_W-1:0] BYTE_PAD     = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_REQ  = 2'd2,
        ST_OUT  = 2'd3
    } hfb_state_e;
endpackage

// File: rtl/hfb_store.sv
module hfb_store #(
    parameter int unsigned DEPTH = 19,
    parameter int unsigned DW    = 8,
    parameter int unsigned AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    input  logic          e_we,
    input  logic [AW-1:0] e_addr,
    input  logic [DW-1:0] e_wdata,
    input  logic [AW-1:0] a_addr,
    output logic [DW-1:0] a_rdata,
    input  logic [AW-1:0] b_addr,
    output logic [DW-1:0] b_rdata,
    output logic [DW-1:0] head
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    // next value of every byte slot; the host port wins a same-address clash
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (e_we && e_addr == AW'(i)) mem_d[i] = e_wdata;
            if (h_we && h_addr == AW'(i)) mem_d[i] = h_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    // two independent read ports; out-of-range addresses read zero
    always_comb begin
        a_rdata = '0;
        b_rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (a_addr == AW'(i)) a_rdata = mem_q[i];
            if (b_addr == AW'(i)) b_rdata = mem_q[i];
        end
    end

    assign head = mem_q[0];
endmodule

// File: rtl/hfb_ctrl.sv
module hfb_ctrl
    import hfb_pkg::*;
#(
    parameter int unsigned DEPTH     = 19,
    parameter int unsigned DW        = 8,
    parameter int unsigned AW        = 5,
    parameter int unsigned MIN_COUNT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_wr,
    input  logic [DW-1:0] h_wdata,
    input  logic          h_rack,
    input  logic          h_end,
    output logic [DW-1:0] h_rdata,
    input  logic          e_we,
    input  logic          e_post,
    input  logic [DW-1:0] head,
    input  logic [DW-1:0] a_rdata,
    output logic          h_we_ok,
    output logic          e_we_ok,
    output logic [AW-1:0] off,
    output logic          req_pend,
    output logic          out_pend,
    output logic          irq,
    output logic          ovr_pulse,
    output logic [DW-1:0] err_code
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW-1:0] CAP  = AW'(DEPTH);
    localparam logic [DW-1:0] MINC = DW'(MIN_COUNT);

    typedef struct packed {
        hfb_state_e    st;
        logic [AW-1:0] off;
        logic          skip;
        logic          rd_seen;
        logic          irq;
        logic          ovr;
        logic [DW-1:0] err;
    } ctl_t;

    ctl_t          r_q, r_d;
    logic          post_ok;
    logic          start_ok;
    logic [DW-1:0] cnt;
    logic [DW:0]   nxt_pos;
    logic [DW:0]   cur_pos;

    always_comb begin
        r_d      = r_q;
        r_d.ovr  = 1'b0;
        r_d.irq  = (r_q.st == ST_OUT);
        cur_pos  = (DW+1)'(r_q.off);
        nxt_pos  = cur_pos + 1'b1;
        post_ok  = e_post && (r_q.st == ST_IDLE || r_q.st == ST_REQ);
        e_we_ok  = e_we && (r_q.st == ST_IDLE || r_q.st == ST_REQ);
        cnt      = (r_q.off == '0) ? h_wdata : head;
        start_ok = (r_q.st == ST_IDLE) && !r_q.skip && (r_q.off == '0);
        h_we_ok  = h_wr && !post_ok &&
                   (start_ok || (r_q.st == ST_FILL && r_q.off < CAP));

        if ((h_wr || h_rack) && r_q.off < CAP) r_d.off = r_q.off + 1'b1;

        // collect a host frame against its own count
        if (h_we_ok) begin
            if (r_q.off == '0 && h_wdata < MINC) begin
                r_d.skip = 1'b1;
                r_d.st   = ST_IDLE;
            end else if (nxt_pos == {1'b0, cnt} || r_q.off == LAST) begin
                r_d.st = ST_REQ;
            end else begin
                r_d.st = ST_FILL;
            end
        end

        // host reading a pending frame; last counted byte releases it
        if (h_rack && r_q.st == ST_OUT) begin
            r_d.rd_seen = 1'b1;
            if (nxt_pos >= {1'b0, head} || r_q.off >= LAST) r_d.st = ST_IDLE;
        end

        // engine publication or refusal
        if (post_ok) begin
            r_d.st = ST_OUT;
        end else if (e_post) begin
            r_d.ovr = 1'b1;
            r_d.err = CODE_OVERRUN;
        end

        // end of a host transfer
        if (h_end) begin
            r_d.off     = '0;
            r_d.skip    = 1'b0;
            r_d.rd_seen = 1'b0;
            if (r_d.st == ST_FILL) r_d.st = ST_IDLE;
            if (r_q.st == ST_OUT && r_d.st == ST_OUT && (r_q.rd_seen || h_rack))
                r_d.st = ST_IDLE;
        end

        // byte presented to the host window
        if (r_q.st == ST_OUT && cur_pos < {1'b0, head} && r_q.off < CAP)
            h_rdata = a_rdata;
        else if (r_q.off == '0)
            h_rdata = BYTE_EMPTY;
        else
            h_rdata = BYTE_PAD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.off     <= '0;
            r_q.skip    <= 1'b0;
            r_q.rd_seen <= 1'b0;
            r_q.irq     <= 1'b0;
            r_q.ovr     <= 1'b0;
            r_q.err     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign off       = r_q.off;
    assign req_pend  = (r_q.st == ST_REQ);
    assign out_pend  = (r_q.st == ST_OUT);
    assign irq       = r_q.irq;
    assign ovr_pulse = r_q.ovr;
    assign err_code  = r_q.err;
endmodule

// File: rtl/hfb_frame_buffer.sv
module hfb_frame_buffer #(
    parameter int unsigned DEPTH     = 19,
    parameter int unsigned DW        = 8,
    parameter int unsigned MIN_COUNT = 3,
    localparam int unsigned AW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr_en,
    input  logic [DW-1:0] host_wr_data,
    input  logic          host_rd_ack,
    input  logic          host_xfer_end,
    output logic [DW-1:0] host_rd_data,
    input  logic          eng_wr_en,
    input  logic [AW-1:0] eng_addr,
    input  logic [DW-1:0] eng_wr_data,
    input  logic          eng_post,
    output logic [DW-1:0] eng_rd_data,
    output logic          req_pending,
    output logic          irq,
    output logic          overrun,
    output logic [DW-1:0] err_code
);
    logic          h_we_w;
    logic          e_we_w;
    logic [AW-1:0] off_w;
    logic [DW-1:0] head_w;
    logic [DW-1:0] a_rdata_w;
    logic          out_pend_w;

    hfb_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_we    (h_we_w),
        .h_addr  (off_w),
        .h_wdata (host_wr_data),
        .e_we    (e_we_w),
        .e_addr  (eng_addr),
        .e_wdata (eng_wr_data),
        .a_addr  (off_w),
        .a_rdata (a_rdata_w),
        .b_addr  (eng_addr),
        .b_rdata (eng_rd_data),
        .head    (head_w)
    );

    hfb_ctrl #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .MIN_COUNT(MIN_COUNT)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .h_wr      (host_wr_en),
        .h_wdata   (host_wr_data),
        .h_rack    (host_rd_ack),
        .h_end     (host_xfer_end),
        .h_rdata   (host_rd_data),
        .e_we      (eng_wr_en),
        .e_post    (eng_post),
        .head      (head_w),
        .a_rdata   (a_rdata_w),
        .h_we_ok   (h_we_w),
        .e_we_ok   (e_we_w),
        .off       (off_w),
        .req_pend  (req_pending),
        .out_pend  (out_pend_w),
        .irq       (irq),
        .ovr_pulse (overrun),
        .err_code  (err_code)
    );
endmodule

// File: rtl/hfb_checker.sv
module hfb_checker #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr_en,
    input logic [DW-1:0] host_rd_data,
    input logic          eng_post,
    input logic          req_pending,
    input logic          irq,
    input logic          overrun,
    input logic [DW-1:0] err_code,
    input logic          out_pend,
    input logic [AW-1:0] off,
    input logic [DW-1:0] head
);
    logic [DW-1:0] off_ext;
    assign off_ext = DW'(off);

    // R2: a request only appears after a host write
    p_submit_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_pending) |-> $past(host_wr_en));

    // R8: a confirmation post retires the request and makes the frame pending
    p_confirm_clears_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pending && eng_post) |=> (!req_pending && out_pend));

    // R8: interrupt follows a newly pending frame by one cycle
    p_irq_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_pend) |=> irq);

    // R7: never a host request and a host-bound frame at the same time
    p_single_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && req_pending));

    // R13: a refused post leaves the overrun code
    p_overrun_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (err_code == 8'h03));

    // R10: offset 0 reads 00h when nothing is pending for the host
    p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_pend && off == '0) |-> (host_rd_data == 8'h00));

    // R9: reads at or past the count are padded
    p_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pend && off_ext >= head) |-> (host_rd_data == 8'hFF));
endmodule

bind hfb_frame_buffer hfb_checker #(.DW(DW), .AW(AW)) i_hfb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_rd_data (host_rd_data),
    .eng_post     (eng_post),
    .req_pending  (req_pending),
    .irq          (irq),
    .overrun      (overrun),
    .err_code     (err_code),
    .out_pend     (out_pend_w),
    .off          (off_w),
    .head         (head_w)
);

// File: tb/test_hfb_frame_buffer.sv
`timescale 1ns/1ps
module test_hfb_frame_buffer;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr_en = 1'b0;
    logic [7:0]    host_wr_data = '0;
    logic          host_rd_ack = 1'b0;
    logic          host_xfer_end = 1'b0;
    logic [7:0]    host_rd_data;
    logic          eng_wr_en = 1'b0;
    logic [AW-1:0] eng_addr = '0;
    logic [7:0]    eng_wr_data = '0;
    logic          eng_post = 1'b0;
    logic [7:0]    eng_rd_data;
    logic          req_pending;
    logic          irq;
    logic          overrun;
    logic [7:0]    err_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    hfb_frame_buffer i_hfb_frame_buffer (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .host_rd_ack(host_rd_ack), .host_xfer_end(host_xfer_end),
        .host_rd_data(host_rd_data),
        .eng_wr_en(eng_wr_en), .eng_addr(eng_addr), .eng_wr_data(eng_wr_data),
        .eng_post(eng_post), .eng_rd_data(eng_rd_data),
        .req_pending(req_pending), .irq(irq), .overrun(overrun),
        .err_code(err_code)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [7:0] d);
        host_wr_en = 1'b1; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic hend();
        host_xfer_end = 1'b1;
        @(negedge clk);
        host_xfer_end = 1'b0;
    endtask

    task automatic hrd(input string tag, input logic [7:0] exp);
        chk(tag, host_rd_data, exp);
        host_rd_ack = 1'b1;
        @(negedge clk);
        host_rd_ack = 1'b0;
    endtask

    task automatic ewr(input logic [AW-1:0] a, input logic [7:0] d);
        eng_wr_en = 1'b1; eng_addr = a; eng_wr_data = d;
        @(negedge clk);
        eng_wr_en = 1'b0;
    endtask

    task automatic epost();
        eng_post = 1'b1;
        @(negedge clk);
        eng_post = 1'b0;
    endtask

    task automatic erd(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
        eng_addr = a;
        #1;
        chk(tag, eng_rd_data, exp);
    endtask

    task automatic drain();
        ewr(5'd0, 8'h03); ewr(5'd1, 8'h01); ewr(5'd2, 8'h00);
        epost();
        @(negedge clk);
        hrd("drain", 8'h03); hrd("drain", 8'h01); hrd("drain", 8'h00);
        hend();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 req_pending", {7'd0, req_pending}, 8'h00);
        chk("R1 overrun", {7'd0, overrun}, 8'h00);
        chk("R1 err_code", err_code, 8'h00);
        chk("R1 rd_data", host_rd_data, 8'h00);
    endtask

    task automatic t_idle_read();
        hrd("R10 offset0", 8'h00);
        hrd("R10 offset1", 8'hFF);
        hrd("R10 offset2", 8'hFF);
        hend();
    endtask

    task automatic t_submit();
        hw(8'h04); hw(8'h00); hw(8'h40);
        chk("R2 not before last byte", {7'd0, req_pending}, 8'h00);
        hw(8'h0D);
        chk("R2 submitted", {7'd0, req_pending}, 8'h01);
        hw(8'h77); hw(8'h88);
        hend();
        chk("R2 still pending", {7'd0, req_pending}, 8'h01);
        erd("R2 byte0", 5'd0, 8'h04);
        erd("R2 byte2", 5'd2, 8'h40);
        erd("R2 byte3", 5'd3, 8'h0D);
        erd("R3 extra byte4", 5'd4, 8'h00);
        erd("R3 extra byte5", 5'd5, 8'h00);
    endtask

    task automatic t_busy();
        hw(8'h05); hw(8'h01); hw(8'h02); hw(8'h03); hw(8'h04);
        hend();
        erd("R7 count kept", 5'd0, 8'h04);
        erd("R7 byte1 kept", 5'd1, 8'h00);
        chk("R7 request kept", {7'd0, req_pending}, 8'h01);
    endtask

    task automatic t_confirm();
        ewr(5'd0, 8'h03); ewr(5'd1, 8'h01); ewr(5'd2, 8'h00);
        epost();
        chk("R8 req cleared", {7'd0, req_pending}, 8'h00);
        chk("R8 irq lag", {7'd0, irq}, 8'h00);
        @(negedge clk);
        chk("R8 irq up", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_overrun_pending();
        ewr(5'd1, 8'hEE);
        epost();
        chk("R13 overrun pulse", {7'd0, overrun}, 8'h01);
        chk("R13 err_code", err_code, 8'h03);
        @(negedge clk);
        chk("R13 pulse ends", {7'd0, overrun}, 8'h00);
        chk("R13 irq kept", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_read_frame();
        hrd("R9 byte0", 8'h03);
        hrd("R13 byte1 unchanged", 8'h01);
        hrd("R9 byte2", 8'h00);
        chk("R11 irq lag", {7'd0, irq}, 8'h01);
        @(negedge clk);
        chk("R11 irq cleared", {7'd0, irq}, 8'h00);
        hrd("R9 past count", 8'hFF);
        hend();
        hrd("R11 frame gone", 8'h00);
        hrd("R11 frame gone pad", 8'hFF);
        hend();
    endtask

    task automatic t_abandon();
        ewr(5'd0, 8'h05); ewr(5'd1, 8'h81); ewr(5'd2, 8'h30);
        ewr(5'd3, 8'h44); ewr(5'd4, 8'h55);
        epost();
        @(negedge clk);
        chk("R12 irq up", {7'd0, irq}, 8'h01);
        hrd("R12 byte0", 8'h05);
        hrd("R12 byte1", 8'h81);
        hend();
        @(negedge clk);
        chk("R12 irq cleared", {7'd0, irq}, 8'h00);
        hrd("R12 discarded", 8'h00);
        hrd("R12 discarded pad", 8'hFF);
        hend();
    endtask

    task automatic t_long();
        hw(8'h20);
        for (int i = 1; i < 18; i++) hw(8'(i));
        chk("R4 not yet", {7'd0, req_pending}, 8'h00);
        hw(8'hA5);
        chk("R4 capped submit", {7'd0, req_pending}, 8'h01);
        hw(8'h5A);
        hend();
        erd("R4 last slot", 5'd18, 8'hA5);
        erd("R4 count", 5'd0, 8'h20);
        drain();
    endtask

    task automatic t_short();
        hw(8'h02); hw(8'h01); hw(8'h02); hw(8'h03);
        chk("R5 count 02", {7'd0, req_pending}, 8'h00);
        hend();
        hw(8'h00); hw(8'h01); hw(8'h02); hw(8'h03);
        chk("R5 count 00", {7'd0, req_pending}, 8'h00);
        hend();
    endtask

    task automatic t_partial();
        hw(8'h05); hw(8'h00); hw(8'h11);
        hend();
        chk("R6 partial dropped", {7'd0, req_pending}, 8'h00);
        hw(8'h03); hw(8'h00); hw(8'h42);
        chk("R6 fresh frame", {7'd0, req_pending}, 8'h01);
        hend();
        erd("R6 fresh byte2", 5'd2, 8'h42);
        drain();
    endtask

    task automatic t_overrun_fill();
        hw(8'h05); hw(8'h00);
        epost();
        chk("R13 refused during fill", {7'd0, overrun}, 8'h01);
        hend();
        chk("R13 no request", {7'd0, req_pending}, 8'h00);
        chk("R13 no irq", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_read();
        t_submit();
        t_busy();
        t_confirm();
        t_overrun_pending();
        t_read_frame();
        t_abandon();
        t_long();
        t_short();
        t_partial();
        t_overrun_fill();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule